// File: doc/BRIEF.md
# Sleep and Measurement-Timing Controller

This block paces a voltage-measurement engine from a slow tick enable, typically derived from a 32 kHz time base. After reset or a restart, the first conversion window is short, 125 ms by default. Every later window is 500 ms. At the end of each window the block raises a one-cycle conversion-done strobe. It also owns the low-power sleep state, and it issues a restart pulse that rewinds the schedule to its power-up form.

Sleep has two independent sources.

- **Bus sleep.** The host holds both synchronised bus lines low for a fixed tick count, 2.0 s by default. The block leaves this sleep on any rising edge of either line.
- **Software sleep.** A register bit forces sleep. This sleep lasts until the bit is cleared, and bus activity does not affect it.

While the block sleeps, the conversion schedule is frozen. On wake, the next result arrives one full regular period later. A restart is requested either by a rising edge on the quick-start pin or by a one-cycle command strobe.

Top module: `sleep_timing_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, sleeping_o, conv_done_o and restart_o are all 0.
- R2: After reset or a restart, the first conv_done_o pulse comes on the FIRST_TICKS-th tick. The pulse appears in the clock cycle after the clock edge that samples that tick, and it lasts exactly one cycle.
- R3: After the first window, conv_done_o pulses once every PERIOD_TICKS ticks.
- R4: While scl_i and sda_i are both 0, ticks are counted. On the BUS_LOW_TICKS-th consecutive tick, sleeping_o goes to 1. A cycle in which either line is 1 resets that count to zero.
- R5: A sleep entered through the bus ends one cycle after a rising edge on scl_i or sda_i, provided the sleep bit is clear.
- R6: sleeping_o follows sleep_bit_i with one cycle of delay whenever sleep_bit_i is 1. Bus-line edges do not end this sleep.
- R7: No conv_done_o pulse is issued while sleeping_o is 1, and ticks during sleep do not advance the schedule.
- R8: After sleeping_o falls, the next conv_done_o comes PERIOD_TICKS ticks later. This holds even if the block slept during its first window.
- R9: A 0-to-1 change of qs_pin_i, or qs_cmd_i high, produces restart_o high in the next cycle. A pin that stays high does not produce a further restart.
- R10: A restart zeroes the schedule. conv_done_o is 0 in the cycle after restart_o, and the next pulse follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick enable, one cycle per tick |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sleep_bit_i | input | 1 | Software sleep request bit |
| qs_pin_i | input | 1 | Quick-start pin; its rising edge restarts the schedule |
| qs_cmd_i | input | 1 | Quick-start command strobe |
| sleeping_o | output | 1 | Block is in sleep |
| conv_done_o | output | 1 | One-cycle end-of-conversion-window strobe |
| restart_o | output | 1 | One-cycle restart pulse |

## Verification
On every cycle, the bound checker enforces several cycle-level rules:

- no conversion strobe while asleep, and none directly after a restart;
- strobes that are always single-cycle;
- software sleep tracking its bit;
- a bus edge ending sleep when the bit is clear.

Only the bench scenarios can show the tick-count behaviour: the short first window against the regular period, the exact bus-low count before entry and its reset by a brief high level, and the full period that follows a wake. The same applies to the edge-only nature of the quick-start pin, and to the rule that bus toggles leave software sleep in place.

// File: rtl/sleep_tmr_pkg.sv
package sleep_tmr_pkg;
  // 32 kHz time base: 125 ms, 500 ms, 2.0 s
  localparam int unsigned DEF_FIRST_TICKS   = 4096;
  localparam int unsigned DEF_PERIOD_TICKS  = 16384;
  localparam int unsigned DEF_BUS_LOW_TICKS = 65536;

  typedef struct packed {
    logic scl_rise;
    logic sda_rise;
  } bus_edge_t;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/stc_restart_gen.sv
module stc_restart_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qs_pin_i,
  input  logic qs_cmd_i,
  output logic restart_o
);
  logic pin_q;
  logic req;

  // pin history resets high so a pin already high at reset is no edge
  assign req = (qs_pin_i & ~pin_q) | qs_cmd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q     <= 1'b1;
      restart_o <= 1'b0;
    end else begin
      pin_q     <= qs_pin_i;
      restart_o <= req;
    end
  end
endmodule

// File: rtl/stc_bus_sleep.sv
module stc_bus_sleep
  import sleep_tmr_pkg::*;
#(
  parameter int unsigned BUS_LOW_TICKS = DEF_BUS_LOW_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic restart_i,
  output logic asleep_o
);
  localparam int unsigned BW = $clog2(BUS_LOW_TICKS + 1);
  localparam logic [BW-1:0] LAST = BW'(BUS_LOW_TICKS - 1);

  logic [BW-1:0] cnt_q;
  logic          scl_q, sda_q;
  bus_edge_t     edg;
  logic          both_low;

  assign edg.scl_rise = scl_i & ~scl_q;
  assign edg.sda_rise = sda_i & ~sda_q;
  assign both_low     = ~scl_i & ~sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      asleep_o <= 1'b0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (restart_i) begin
        asleep_o <= 1'b0;
        cnt_q    <= '0;
      end else if (asleep_o) begin
        cnt_q <= '0;
        if (edg.scl_rise || edg.sda_rise) asleep_o <= 1'b0;
      end else if (!both_low) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == LAST) begin
          asleep_o <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stc_conv_timer.sv
module stc_conv_timer
  import sleep_tmr_pkg::*;
#(
  parameter int unsigned FIRST_TICKS  = DEF_FIRST_TICKS,
  parameter int unsigned PERIOD_TICKS = DEF_PERIOD_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic halt_i,
  input  logic restart_i,
  output logic conv_done_o
);
  localparam int unsigned CW = $clog2(max_u(FIRST_TICKS, PERIOD_TICKS) + 1);
  localparam logic [CW-1:0] FIRST_LAST  = CW'(FIRST_TICKS - 1);
  localparam logic [CW-1:0] PERIOD_LAST = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          halt_q;
  logic          wake;
  logic [CW-1:0] limit;

  assign wake  = halt_q & ~halt_i;
  assign limit = first_q ? FIRST_LAST : PERIOD_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      first_q     <= 1'b1;
      halt_q      <= 1'b0;
      conv_done_o <= 1'b0;
    end else begin
      halt_q      <= halt_i;
      conv_done_o <= 1'b0;
      if (restart_i) begin
        cnt_q   <= '0;
        first_q <= 1'b1;
      end else if (wake) begin
        // full regular window after any wake
        cnt_q   <= '0;
        first_q <= 1'b0;
      end else if (tick_i && !halt_i) begin
        if (cnt_q == limit) begin
          cnt_q       <= '0;
          first_q     <= 1'b0;
          conv_done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sleep_timing_ctrl.sv
module sleep_timing_ctrl
  import sleep_tmr_pkg::*;
#(
  parameter int unsigned FIRST_TICKS   = DEF_FIRST_TICKS,
  parameter int unsigned PERIOD_TICKS  = DEF_PERIOD_TICKS,
  parameter int unsigned BUS_LOW_TICKS = DEF_BUS_LOW_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sleep_bit_i,
  input  logic qs_pin_i,
  input  logic qs_cmd_i,
  output logic sleeping_o,
  output logic conv_done_o,
  output logic restart_o
);
  logic sw_sleep_q;
  logic bus_sleep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_sleep_q <= 1'b0;
    else         sw_sleep_q <= sleep_bit_i;
  end

  assign sleeping_o = sw_sleep_q | bus_sleep;

  stc_restart_gen u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qs_pin_i (qs_pin_i),
    .qs_cmd_i (qs_cmd_i),
    .restart_o(restart_o)
  );

  stc_bus_sleep #(.BUS_LOW_TICKS(BUS_LOW_TICKS)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .restart_i(restart_o),
    .asleep_o (bus_sleep)
  );

  stc_conv_timer #(
    .FIRST_TICKS (FIRST_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_conv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .halt_i     (sleeping_o),
    .restart_i  (restart_o),
    .conv_done_o(conv_done_o)
  );
endmodule

// File: rtl/stc_checker.sv
module stc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic sleep_bit_i,
  input logic sleeping_o,
  input logic conv_done_o,
  input logic restart_o
);
  AST_NO_DONE_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleeping_o) |-> !conv_done_o); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |=> !conv_done_o); // R2

  AST_SW_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_bit_i |=> sleeping_o); // R6

  AST_BUS_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($rose(scl_i) || $rose(sda_i)) && !sleep_bit_i) |=> !sleeping_o); // R5

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !conv_done_o); // R10
endmodule

bind sleep_timing_ctrl stc_checker u_chk (.*);

// File: tb/sim_sleep_timing_ctrl.sv
module sim_sleep_timing_ctrl;
  localparam int unsigned FT = 5;
  localparam int unsigned PT = 12;
  localparam int unsigned BT = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 0, scl = 1, sda = 1, sbit = 0, qpin = 0, qcmd = 0;
  logic sleeping, done, rst_p;
  int checks = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sleep_timing_ctrl #(.FIRST_TICKS(FT), .PERIOD_TICKS(PT), .BUS_LOW_TICKS(BT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .scl_i(scl), .sda_i(sda),
    .sleep_bit_i(sbit), .qs_pin_i(qpin), .qs_cmd_i(qcmd),
    .sleeping_o(sleeping), .conv_done_o(done), .restart_o(rst_p));

  always @(negedge clk) if (rst_ni && done) done_cnt++;

  // {ticks, expected strobes}; starts right after reset
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{4, 0}, '{1, 1}, '{11, 0}, '{1, 1}, '{24, 2}, '{3, 0}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(string req, int n, int exp);
    int b;
    b = done_cnt;
    ticks(n);
    cyc(1);
    chk(req, done_cnt - b, exp);
  endtask

  initial begin
    cyc(2);
    chk("R1 sleeping", sleeping, 0);
    chk("R1 done", done, 0);
    chk("R1 restart", rst_p, 0);
    @(negedge clk) rst_ni = 1;
    @(negedge clk);
    chk("R1 post-reset", {sleeping, done, rst_p}, 0);

    for (int v = 0; v < NV; v++) window(v < 2 ? "R2 first window" : "R3 period", VEC[v][0], VEC[v][1]);

    // bus-held sleep
    scl = 0; sda = 0;
    ticks(BT - 1); cyc(1);
    chk("R4 before count", sleeping, 0);
    ticks(1); cyc(1);
    chk("R4 entered", sleeping, 1);
    window("R7 halted", 15, 0);
    @(negedge clk) scl = 1;
    @(negedge clk);
    chk("R5 scl wake", sleeping, 0);
    sda = 1; cyc(2);
    window("R8 after wake", PT - 1, 0);
    window("R8 full period", 1, 1);

    // a brief high restarts the bus-low count
    scl = 0; sda = 0;
    ticks(15);
    @(negedge clk) sda = 1;
    @(negedge clk) sda = 0;
    ticks(15); cyc(1);
    chk("R4 count reset by high", sleeping, 0);
    ticks(5); cyc(1);
    chk("R4 entered again", sleeping, 1);
    @(negedge clk) sda = 1;
    @(negedge clk);
    chk("R5 sda wake", sleeping, 0);
    scl = 1; cyc(2);

    // software sleep
    @(negedge clk) sbit = 1;
    cyc(1);
    chk("R6 sw entered", sleeping, 1);
    @(negedge clk) scl = 0;
    @(negedge clk) scl = 1;
    @(negedge clk) sda = 0;
    @(negedge clk) sda = 1;
    cyc(1);
    chk("R6 bus edges ignored", sleeping, 1);
    window("R7 sw halted", 20, 0);
    @(negedge clk) sbit = 0;
    cyc(1);
    chk("R6 bit cleared", sleeping, 0);
    cyc(2);
    window("R8 sw wake", PT - 1, 0);
    window("R8 sw full period", 1, 1);

    // quick-start pin
    window("R10 mid period", 7, 0);
    @(negedge clk) qpin = 1;
    @(negedge clk);
    chk("R9 pin restart", rst_p, 1);
    chk("R10 no strobe", done, 0);
    @(negedge clk);
    chk("R9 single cycle", rst_p, 0);
    cyc(3);
    chk("R9 held pin", rst_p, 0);
    window("R10 first window open", FT - 1, 0);
    window("R10 first window end", 1, 1);
    qpin = 0;

    // quick-start command
    window("R10 mid period cmd", 8, 0);
    @(negedge clk) qcmd = 1;
    @(negedge clk) qcmd = 0;
    chk("R9 cmd restart", rst_p, 1);
    cyc(1);
    window("R10 cmd first window", FT, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule